// File: doc/BRIEF.md
# Serial Register Write Receiver

This block takes configuration writes from a three-wire serial port made up of a serial clock, an active-low frame sync and serial data. It runs on the system clock and oversamples the serial clock. Each serial clock falling edge is one sampling point. A high-to-low change of the frame sync seen at a sampling point opens a frame. The next 32 sampling points shift in one word, most significant bit first. The upper 16 bits are a register address and the lower 16 bits are the data. The block keeps three registers: control, gain and over-range threshold.

Several receivers can be chained so that they share one frame sync, with each data input fed from the previous device's data output. While the frame sync stays low past the end of a word, the block passes that word on and does not store it. It then connects its serial data input straight to its serial data output, so that the following words reach the devices further down the chain. The word a device keeps is the one during which the frame sync was released. If the device is not forwarding, its serial output carries an ordinary read stream that another block supplies.

Four control bits act as commands rather than settings. They raise a one-cycle pulse and are never stored. The power, reference-buffer and amplifier control bits are brought out as levels.

Top module: `wrx_top`

## Requirements
- R1: After reset the control register reads 0x001A, gain reads 0xA000, the threshold reads 0xCCCC, forwarding is off and no command pulse is raised.
- R2: A frame opens when the frame sync is low at a serial clock falling edge and was high at the previous one. The next 32 falling edges latch data bits most significant bit first, with the address in bits 31:16 and the data in bits 15:0.
- R3: A stored write is visible on the register outputs right after the system clock edge that latches bit 0. Address 0x0001 selects control, 0x0004 selects gain and 0x0005 selects the threshold, with the full 16-bit address compared.
- R4: A write to any other address leaves all three registers unchanged and raises no pulse.
- R5: A falling edge of the frame sync while a frame is open does not restart it, and the write still completes at the 32nd data bit.
- R6: If the frame sync is still low at the falling edge that latches bit 0 of a word, that word is discarded and forwarding turns on (sdo follows sdi). Words keep arriving, and the first word during whose 32 data edges the frame sync is seen high is stored. Forwarding turns off at that store.
- R7: Control bits 14, 13, 11 and 9 each raise a one-system-clock pulse on rd_ovr_pulse, rd_gain_pulse, rd_stat_pulse and sync_pulse respectively, and always read back as 0 in ctrl_q.
- R8: If more than one of control bits 14, 13 and 11 is set in a single write, none of the three read pulses is raised. The other bits are still stored, and bit 9 still pulses.
- R9: pwr_down equals control bit 3, ref_buf_off equals control bit 1 and amp_off equals control bit 0.
- R10: While forwarding is off, sdo equals rd_sdo.
- R11: A frame sync held low for exactly 32 serial clock periods still stores the word on its own device, and forwarding stays off.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sck | input | 1 | Serial clock, synchronous to clk |
| fs_n | input | 1 | Active-low frame sync |
| sdi | input | 1 | Serial data in |
| rd_sdo | input | 1 | Read data stream from the conversion output path |
| sdo | output | 1 | Serial data out (forwarded sdi or rd_sdo) |
| fwd_en | output | 1 | Forwarding to downstream devices active |
| ctrl_q | output | 16 | Control register |
| gain_q | output | 16 | Gain register |
| thr_q | output | 16 | Over-range threshold register |
| rd_ovr_pulse | output | 1 | Read-threshold command pulse |
| rd_gain_pulse | output | 1 | Read-gain command pulse |
| rd_stat_pulse | output | 1 | Read-status command pulse |
| sync_pulse | output | 1 | Filter synchronisation command pulse |
| pwr_down | output | 1 | Power-down level |
| ref_buf_off | output | 1 | Reference buffer off level |
| amp_off | output | 1 | Input amplifier off level |

## Verification
Two things can happen at the same serial clock edge: the store of a chained word and the end of forwarding. Both are decided at the falling edge that latches bit 0. The bench provokes this by holding the frame sync low for 40, 64 and 70 periods across two- and three-word frames. It then checks that only the last word lands in the register, that sdo followed sdi in the middle of the run, and that forwarding has dropped once the frame is over. A control write can also carry several commands at once. The bench sends words with several read-select bits set, and with a read select together with the sync bit. It then counts the pulse cycles on each output.

// File: rtl/wrx_pkg.sv
package wrx_pkg;

  typedef enum logic {RX_IDLE, RX_BUSY} rx_state_t;

  // control field positions that neighbours decode
  localparam int B_RD_OVR  = 14;
  localparam int B_RD_GAIN = 13;
  localparam int B_RD_STAT = 11;
  localparam int B_SYNC    = 9;
  localparam int B_PDN     = 3;
  localparam int B_REF     = 1;
  localparam int B_AMP     = 0;

  // at most one read selection may be honoured per write
  function automatic logic rd_sel_ok(input logic a, input logic b, input logic c);
    return ({1'b0, a} + {1'b0, b} + {1'b0, c}) <= 2'd1;
  endfunction

  // frame ends when the sync was seen released in the current word window
  function automatic logic frame_closes(input logic seen_hi, input logic fs_now);
    return seen_hi | fs_now;
  endfunction

endpackage

// File: rtl/wrx_edge_det.sv
module wrx_edge_det (
  input  logic clk,
  input  logic rst_n,
  input  logic sck,
  output logic fall
);
  logic sck_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sck_q <= 1'b0;
    else        sck_q <= sck;
  end

  assign fall = sck_q & ~sck;
endmodule

// File: rtl/wrx_frame_rx.sv
module wrx_frame_rx #(
  parameter int FRAME_W = 32
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               fall,
  input  logic               fs_n,
  input  logic               sdi,
  output logic [FRAME_W-1:0] word,
  output logic               commit,
  output logic               fwd_en
);
  import wrx_pkg::*;

  localparam int CNT_W = $clog2(FRAME_W);
  localparam logic [CNT_W-1:0] LAST = CNT_W'(FRAME_W - 1);

  rx_state_t          state;
  logic [FRAME_W-2:0] sreg;
  logic [CNT_W-1:0]   bit_cnt;
  logic               seen_hi;
  logic               fs_last;

  logic start, shift, word_done, seen_next;

  assign start     = fall && (state == RX_IDLE) && fs_last && !fs_n;
  assign shift     = fall && (state == RX_BUSY);
  assign word_done = shift && (bit_cnt == LAST);
  assign seen_next = frame_closes(seen_hi, fs_n);
  assign commit    = word_done && seen_next;
  assign word      = {sreg, sdi};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state   <= RX_IDLE;
      sreg    <= '0;
      bit_cnt <= '0;
      seen_hi <= 1'b0;
      fs_last <= 1'b1;
      fwd_en  <= 1'b0;
    end else if (fall) begin
      fs_last <= fs_n;
      if (start) begin
        state   <= RX_BUSY;
        bit_cnt <= '0;
        seen_hi <= 1'b0;
      end else if (shift) begin
        sreg <= word[FRAME_W-2:0];
        if (word_done) begin
          bit_cnt <= '0;
          seen_hi <= 1'b0;
          if (commit) begin
            state  <= RX_IDLE;
            fwd_en <= 1'b0;
          end else begin
            fwd_en <= 1'b1;
          end
        end else begin
          bit_cnt <= bit_cnt + 1'b1;
          seen_hi <= seen_next;
        end
      end
    end
  end
endmodule

// File: rtl/wrx_reg_bank.sv
module wrx_reg_bank #(
  parameter int ADDR_W = 16,
  parameter int DATA_W = 16,
  parameter logic [ADDR_W-1:0] ADR_CTRL = 16'h0001,
  parameter logic [ADDR_W-1:0] ADR_GAIN = 16'h0004,
  parameter logic [ADDR_W-1:0] ADR_THR  = 16'h0005,
  parameter logic [DATA_W-1:0] DEF_CTRL = 16'h001A,
  parameter logic [DATA_W-1:0] DEF_GAIN = 16'hA000,
  parameter logic [DATA_W-1:0] DEF_THR  = 16'hCCCC
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     commit,
  input  logic [ADDR_W+DATA_W-1:0] word,
  output logic [DATA_W-1:0]        ctrl_q,
  output logic [DATA_W-1:0]        gain_q,
  output logic [DATA_W-1:0]        thr_q,
  output logic                     rd_ovr_pulse,
  output logic                     rd_gain_pulse,
  output logic                     rd_stat_pulse,
  output logic                     sync_pulse
);
  import wrx_pkg::*;

  localparam logic [DATA_W-1:0] ONE = DATA_W'(1);
  localparam logic [DATA_W-1:0] SELF_MASK =
    (ONE << B_RD_OVR) | (ONE << B_RD_GAIN) | (ONE << B_RD_STAT) | (ONE << B_SYNC);

  logic [ADDR_W-1:0] addr;
  logic [DATA_W-1:0] data;
  logic hit_ctrl, hit_gain, hit_thr, rd_ok;

  assign addr     = word[ADDR_W+DATA_W-1:DATA_W];
  assign data     = word[DATA_W-1:0];
  assign hit_ctrl = commit && (addr == ADR_CTRL);
  assign hit_gain = commit && (addr == ADR_GAIN);
  assign hit_thr  = commit && (addr == ADR_THR);
  assign rd_ok    = rd_sel_ok(data[B_RD_OVR], data[B_RD_GAIN], data[B_RD_STAT]);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_q        <= DEF_CTRL & ~SELF_MASK;
      gain_q        <= DEF_GAIN;
      thr_q         <= DEF_THR;
      rd_ovr_pulse  <= 1'b0;
      rd_gain_pulse <= 1'b0;
      rd_stat_pulse <= 1'b0;
      sync_pulse    <= 1'b0;
    end else begin
      if (hit_ctrl) ctrl_q <= data & ~SELF_MASK;
      if (hit_gain) gain_q <= data;
      if (hit_thr)  thr_q  <= data;
      rd_ovr_pulse  <= hit_ctrl && rd_ok && data[B_RD_OVR];
      rd_gain_pulse <= hit_ctrl && rd_ok && data[B_RD_GAIN];
      rd_stat_pulse <= hit_ctrl && rd_ok && data[B_RD_STAT];
      sync_pulse    <= hit_ctrl && data[B_SYNC];
    end
  end
endmodule

// File: rtl/wrx_top.sv
module wrx_top #(
  parameter int ADDR_W = 16,
  parameter int DATA_W = 16,
  parameter logic [ADDR_W-1:0] ADR_CTRL = 16'h0001,
  parameter logic [ADDR_W-1:0] ADR_GAIN = 16'h0004,
  parameter logic [ADDR_W-1:0] ADR_THR  = 16'h0005,
  parameter logic [DATA_W-1:0] DEF_CTRL = 16'h001A,
  parameter logic [DATA_W-1:0] DEF_GAIN = 16'hA000,
  parameter logic [DATA_W-1:0] DEF_THR  = 16'hCCCC
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sck,
  input  logic              fs_n,
  input  logic              sdi,
  input  logic              rd_sdo,
  output logic              sdo,
  output logic              fwd_en,
  output logic [DATA_W-1:0] ctrl_q,
  output logic [DATA_W-1:0] gain_q,
  output logic [DATA_W-1:0] thr_q,
  output logic              rd_ovr_pulse,
  output logic              rd_gain_pulse,
  output logic              rd_stat_pulse,
  output logic              sync_pulse,
  output logic              pwr_down,
  output logic              ref_buf_off,
  output logic              amp_off
);
  import wrx_pkg::*;

  localparam int FRAME_W = ADDR_W + DATA_W;

  // named internal events for the checker
  logic               fall;
  logic               commit;
  logic [FRAME_W-1:0] rx_word;

  wrx_edge_det u_edge (
    .clk(clk), .rst_n(rst_n), .sck(sck), .fall(fall)
  );

  wrx_frame_rx #(.FRAME_W(FRAME_W)) u_rx (
    .clk(clk), .rst_n(rst_n), .fall(fall), .fs_n(fs_n), .sdi(sdi),
    .word(rx_word), .commit(commit), .fwd_en(fwd_en)
  );

  wrx_reg_bank #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W),
    .ADR_CTRL(ADR_CTRL), .ADR_GAIN(ADR_GAIN), .ADR_THR(ADR_THR),
    .DEF_CTRL(DEF_CTRL), .DEF_GAIN(DEF_GAIN), .DEF_THR(DEF_THR)
  ) u_regs (
    .clk(clk), .rst_n(rst_n), .commit(commit), .word(rx_word),
    .ctrl_q(ctrl_q), .gain_q(gain_q), .thr_q(thr_q),
    .rd_ovr_pulse(rd_ovr_pulse), .rd_gain_pulse(rd_gain_pulse),
    .rd_stat_pulse(rd_stat_pulse), .sync_pulse(sync_pulse)
  );

  assign sdo         = fwd_en ? sdi : rd_sdo;
  assign pwr_down    = ctrl_q[B_PDN];
  assign ref_buf_off = ctrl_q[B_REF];
  assign amp_off     = ctrl_q[B_AMP];
endmodule

// File: rtl/wrx_chk.sv
module wrx_chk #(
  parameter int ADDR_W = 16,
  parameter int DATA_W = 16,
  parameter logic [ADDR_W-1:0] ADR_GAIN = 16'h0004
) (
  input logic                     clk,
  input logic                     rst_n,
  input logic                     fall,
  input logic                     commit,
  input logic [ADDR_W+DATA_W-1:0] rx_word,
  input logic                     fwd_en,
  input logic [DATA_W-1:0]        ctrl_q,
  input logic [DATA_W-1:0]        gain_q,
  input logic [DATA_W-1:0]        thr_q,
  input logic                     rd_ovr_pulse,
  input logic                     rd_gain_pulse,
  input logic                     rd_stat_pulse,
  input logic                     sync_pulse
);
  logic [ADDR_W-1:0] w_addr;
  logic [DATA_W-1:0] w_data;
  assign w_addr = rx_word[ADDR_W+DATA_W-1:DATA_W];
  assign w_data = rx_word[DATA_W-1:0];

  p_gain_write_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (commit && w_addr == ADR_GAIN) |=> (gain_q == $past(w_data)));

  p_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !commit |=> ($stable(gain_q) && $stable(thr_q) && $stable(ctrl_q)));

  p_fwd_rise_r6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(fwd_en) |-> $past(fall));

  p_fwd_clear_r6: assert property (@(posedge clk) disable iff (!rst_n)
    commit |=> !fwd_en);

  p_sync_once_r7: assert property (@(posedge clk) disable iff (!rst_n)
    sync_pulse |=> !sync_pulse);

  p_read_once_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_ovr_pulse || rd_gain_pulse || rd_stat_pulse) |=>
      !(rd_ovr_pulse || rd_gain_pulse || rd_stat_pulse));

  p_one_read_r8: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({rd_ovr_pulse, rd_gain_pulse, rd_stat_pulse}));

  p_pulse_cause_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (sync_pulse || rd_ovr_pulse) |-> $past(commit));
endmodule

bind wrx_top wrx_chk #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .ADR_GAIN(ADR_GAIN)) u_chk (
  .clk(clk), .rst_n(rst_n), .fall(fall), .commit(commit), .rx_word(rx_word),
  .fwd_en(fwd_en), .ctrl_q(ctrl_q), .gain_q(gain_q), .thr_q(thr_q),
  .rd_ovr_pulse(rd_ovr_pulse), .rd_gain_pulse(rd_gain_pulse),
  .rd_stat_pulse(rd_stat_pulse), .sync_pulse(sync_pulse)
);

// File: tb/sim_wrx_top.sv
`timescale 1ns/1ps
module sim_wrx_top;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic sck = 1'b0, fs_n = 1'b1, sdi = 1'b0, rd_sdo = 1'b0;
  logic sdo, fwd_en, rd_ovr_pulse, rd_gain_pulse, rd_stat_pulse, sync_pulse;
  logic pwr_down, ref_buf_off, amp_off;
  logic [15:0] ctrl_q, gain_q, thr_q;

  int nchk = 0, nerr = 0;
  logic [7:0] c_ovr = 0, c_gain = 0, c_stat = 0, c_sync = 0;

  always #4 clk = ~clk;

  wrx_top u0 (
    .clk(clk), .rst_n(rst_n), .sck(sck), .fs_n(fs_n), .sdi(sdi), .rd_sdo(rd_sdo),
    .sdo(sdo), .fwd_en(fwd_en), .ctrl_q(ctrl_q), .gain_q(gain_q), .thr_q(thr_q),
    .rd_ovr_pulse(rd_ovr_pulse), .rd_gain_pulse(rd_gain_pulse),
    .rd_stat_pulse(rd_stat_pulse), .sync_pulse(sync_pulse),
    .pwr_down(pwr_down), .ref_buf_off(ref_buf_off), .amp_off(amp_off)
  );

  always @(posedge clk) begin
    if (rd_ovr_pulse)  c_ovr  <= c_ovr + 1;
    if (rd_gain_pulse) c_gain <= c_gain + 1;
    if (rd_stat_pulse) c_stat <= c_stat + 1;
    if (sync_pulse)    c_sync <= c_sync + 1;
  end

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    nchk++;
    if (act !== exp) begin
      nerr++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic clr_pulses();
    @(negedge clk);
    c_ovr = 0; c_gain = 0; c_stat = 0; c_sync = 0;
  endtask

  // one serial clock period: high 2 clk, low 2 clk; falling edge mid-period
  task automatic tick(input logic fs, input logic d);
    @(negedge clk);
    sck = 1'b1; fs_n = fs; sdi = d; rd_sdo = ~d;
    @(negedge clk);
    @(negedge clk);
    sck = 1'b0;
    @(negedge clk);
  endtask

  // R2 stream: fall 0 opens the frame, falls 1..32*nw carry words MSB first
  task automatic run_frame(input int nw, input logic [31:0] w0, input logic [31:0] w1,
                           input logic [31:0] w2, input int low_per, input int refall);
    for (int p = 0; p <= 32 * nw; p++) begin
      logic fs, d;
      logic [31:0] w;
      if (refall > 0) fs = !(p == 0 || p == refall);
      else            fs = !(p < low_per);
      if (p == 0) d = 1'b0;
      else begin
        w = ((p - 1) / 32 == 0) ? w0 : (((p - 1) / 32 == 1) ? w1 : w2);
        d = w[31 - ((p - 1) % 32)];
      end
      tick(fs, d);
      if (nw > 1 && p == 34) begin
        chk("R6 fwd_en on while sync held", {31'b0, fwd_en}, 32'd1);
        chk("R6 sdo follows sdi", {31'b0, sdo}, {31'b0, sdi});
      end
    end
    tick(1'b1, 1'b0);
    tick(1'b1, 1'b0);
  endtask

  // {addr, data, exp ctrl, exp gain, exp thr, exp pulses {ovr,gain,stat,sync}}
  // R3 valid addresses, R4 unknown, R7 self-clear, R8 multi-select, R9 levels
  localparam int NV = 9;
  localparam logic [83:0] VEC [NV] = '{
    {16'h0004, 16'h1234, 16'h001A, 16'h1234, 16'hCCCC, 4'b0000},
    {16'h0005, 16'h8001, 16'h001A, 16'h1234, 16'h8001, 4'b0000},
    {16'h0002, 16'hFFFF, 16'h001A, 16'h1234, 16'h8001, 4'b0000},
    {16'h0001, 16'h4000, 16'h0000, 16'h1234, 16'h8001, 4'b1000},
    {16'h0001, 16'h2208, 16'h0008, 16'h1234, 16'h8001, 4'b0101},
    {16'h0001, 16'h6803, 16'h0003, 16'h1234, 16'h8001, 4'b0000},
    {16'h0001, 16'h0800, 16'h0000, 16'h1234, 16'h8001, 4'b0010},
    {16'h1004, 16'h5555, 16'h0000, 16'h1234, 16'h8001, 4'b0000},
    {16'h0001, 16'h020A, 16'h000A, 16'h1234, 16'h8001, 4'b0001}
  };

  initial begin
    repeat (200000) @(posedge clk);
    nchk++; nerr++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("Result: errors=%0d of %0d checks", nerr, nchk);
    $finish;
  end

  initial begin
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);

    // R1 reset state, R9 level outputs from default control
    chk("R1 ctrl reset", {16'b0, ctrl_q}, 32'h001A);
    chk("R1 gain reset", {16'b0, gain_q}, 32'hA000);
    chk("R1 thr reset",  {16'b0, thr_q},  32'hCCCC);
    chk("R1 fwd_en reset", {31'b0, fwd_en}, 32'd0);
    chk("R1 no pulses", {28'b0, rd_ovr_pulse, rd_gain_pulse, rd_stat_pulse, sync_pulse}, 32'd0);
    chk("R9 levels at reset", {29'b0, pwr_down, ref_buf_off, amp_off}, 32'b110);

    // R10 read stream passes when not forwarding
    @(negedge clk); rd_sdo = 1'b1; sdi = 1'b0; @(negedge clk);
    chk("R10 sdo=rd_sdo high", {31'b0, sdo}, 32'd1);
    rd_sdo = 1'b0; sdi = 1'b1; @(negedge clk);
    chk("R10 sdo=rd_sdo low", {31'b0, sdo}, 32'd0);

    for (int i = 0; i < NV; i++) begin
      logic [83:0] v;
      v = VEC[i];
      clr_pulses();
      run_frame(1, v[83:52], 32'h0, 32'h0, 1 + (i * 5) % 32, 0);
      chk("R3/R7 ctrl_q", {16'b0, ctrl_q}, {16'b0, v[51:36]});
      chk("R3/R4 gain_q", {16'b0, gain_q}, {16'b0, v[35:20]});
      chk("R3/R4 thr_q",  {16'b0, thr_q},  {16'b0, v[19:4]});
      chk("R7/R8 pulse counts", {c_ovr, c_gain, c_stat, c_sync},
          {7'b0, v[3], 7'b0, v[2], 7'b0, v[1], 7'b0, v[0]});
      chk("R9 level outputs", {29'b0, pwr_down, ref_buf_off, amp_off},
          {29'b0, v[39], v[37], v[36]});
      chk("R2 fwd_en off single word", {31'b0, fwd_en}, 32'd0);
    end

    // R11 sync low exactly 32 periods
    run_frame(1, {16'h0004, 16'h0F0F}, 32'h0, 32'h0, 32, 0);
    chk("R11 gain at 32-period boundary", {16'b0, gain_q}, 32'h0F0F);
    chk("R11 no forwarding", {31'b0, fwd_en}, 32'd0);

    // R5 second sync fall inside the frame is ignored
    run_frame(1, {16'h0004, 16'h7E81}, 32'h0, 32'h0, 1, 10);
    chk("R5 gain after inner sync fall", {16'b0, gain_q}, 32'h7E81);
    run_frame(1, {16'h0005, 16'h1111}, 32'h0, 32'h0, 3, 0);
    chk("R5 next frame thr", {16'b0, thr_q}, 32'h1111);
    chk("R5 gain untouched", {16'b0, gain_q}, 32'h7E81);

    // R6 two-device chain, released mid second word
    run_frame(2, {16'h0004, 16'hDEAD}, {16'h0004, 16'hBEEF}, 32'h0, 40, 0);
    chk("R6 last word kept", {16'b0, gain_q}, 32'hBEEF);
    chk("R6 forwarding ends", {31'b0, fwd_en}, 32'd0);

    // R6 two-device chain at 64-period boundary
    run_frame(2, {16'h0005, 16'hAAAA}, {16'h0005, 16'h3C3C}, 32'h0, 64, 0);
    chk("R6 boundary 64 keeps second", {16'b0, thr_q}, 32'h3C3C);

    // R6 three-device chain
    run_frame(3, {16'h0004, 16'h1111}, {16'h0004, 16'h2222}, {16'h0004, 16'h3333}, 70, 0);
    chk("R6 three-word chain keeps third", {16'b0, gain_q}, 32'h3333);
    chk("R6 forwarding ends after chain", {31'b0, fwd_en}, 32'd0);
    rd_sdo = 1'b1; sdi = 1'b0; @(negedge clk);
    chk("R10 read stream restored", {31'b0, sdo}, 32'd1);

    $display("Result: errors=%0d of %0d checks", nerr, nchk);
    $finish;
  end
endmodule